// File: doc/BRIEF.md
# Three-Level Haar Lifting Temporal Filter

This block applies a Haar wavelet in lifting form along the time axis of a single pixel position. A group of eight frames gives eight co-located signed values, and three lifting levels run on them. At each level the current low-pass run is split into even and odd members. A predict step turns each odd member into a high-pass residual by subtracting its even neighbour. An update step then adds half of that residual back to the even member to give the next low-pass value. Only the low-pass values of one level are passed on to the next level.

Values enter one per cycle through a valid/ready handshake in frame order. Once the eighth value has been taken, the block emits eight tagged results through a valid/ready output stream, then returns to accepting input. The output is ordered finest level first and ends with the single remaining low-pass value. A receiver can therefore drop the finest high-pass levels and still rebuild the sequence at a half or a quarter of the frame rate.

A mode input chooses forward analysis or inverse synthesis. In synthesis the block takes eight coefficients in the same order it emits them in analysis. It first undoes each update and then each prediction, and returns the original frames bit-exactly.

Top module: `haar_temporal_filter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. in_ready and out_valid are never both 1: the block either collects input or emits results.
- R2: Input values are taken on cycles where in_valid and in_ready are both 1, and are assigned to frames 0 to 7 in arrival order. The cycle after the eighth accept, out_valid is 1 and the first result is on the outputs.
- R3: At each level, for each pair k, the high-pass value is odd minus even: h[k] = x[2k+1] - x[2k]. The low-pass value is l[k] = x[2k] + (h[k] >>> 1), an arithmetic shift that rounds toward minus infinity.
- R4: Level 1 works on the eight inputs. Level 2 works on the four level-1 low-pass values, and level 3 on the two level-2 low-pass values.
- R5: Analysis results come out in this order: four level-1 high-pass values (index 0 to 3), two level-2 high-pass values (index 0 to 1), one level-3 high-pass value (index 0), then the final low-pass value. Each result carries a tag. out_is_low is 0 for high-pass and 1 for low-pass, out_level is 1 to 3, and out_index is the position within the level. The final low-pass value is tagged is_low=1, level=3, index=0.
- R6: In synthesis, the eight inputs are coefficients in the R5 order. The outputs are the rebuilt frames 0 to 7, tagged is_low=1, level=0, index equal to the frame number, and they equal the frames that produced the coefficients exactly.
- R7: mode_i (0 = analysis, 1 = synthesis) is sampled together with the first value of a group. Changes on later cycles of the same group have no effect on that group's results.
- R8: While out_valid is 1 and out_ready is 0, out_data and all tag outputs stay unchanged.
- R9: A new group is accepted only after the eighth result has been handed off. in_valid raised during emission is not taken: in_ready stays 0, and the held value becomes frame 0 of the next group.
- R10: Results are COEF_W = SAMPLE_W + 3 bits wide and signed. Full-range SAMPLE_W-bit inputs, including alternating extremes, produce exact results with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = analysis, 1 = synthesis; sampled with the first value of a group |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take an input value |
| in_data | input | COEF_W | Signed frame value (analysis) or coefficient (synthesis) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | COEF_W | Signed result value |
| out_is_low | output | 1 | 1 for low-pass values and rebuilt frames, 0 for high-pass values |
| out_level | output | 2 | Temporal level 1 to 3; 0 for rebuilt frames |
| out_index | output | 3 | Position of the result within its level |

## Verification
The last output handoff of one group and a pending input request for the next group can fall in the same cycle. The bench presents back-to-back groups so that in_valid is already high, with the next group's first value, throughout emission and on the cycle the eighth result is taken. The bench judges this in three ways. in_ready must read 0 on every emitting cycle. Every result of the current group must match the reference. The held value must then arrive as frame 0 of the following group, which shows up in that group's coefficients. Random output stalls push that final handoff onto different cycles relative to the held request.

// File: rtl/htf_pkg.sv
package htf_pkg;

    localparam int GROUP  = 8;
    localparam int NLEV   = 3;
    localparam int IDX_W  = $clog2(GROUP);
    localparam int LVL_W  = $clog2(NLEV + 1);
    localparam int CHAIN  = 2 * GROUP - 1;

    typedef enum logic {
        MODE_ANALYSIS  = 1'b0,
        MODE_SYNTHESIS = 1'b1
    } lift_mode_e;

    typedef enum logic {
        PH_COLLECT = 1'b0,
        PH_EMIT    = 1'b1
    } phase_e;

    typedef struct packed {
        logic             is_low;
        logic [LVL_W-1:0] level;
        logic [IDX_W-1:0] index;
    } coef_tag_t;

    // Tag of an analysis result by its position in the output stream.
    function automatic coef_tag_t analysis_tag(input logic [IDX_W-1:0] slot);
        coef_tag_t t;
        int        base;
        t    = '0;
        base = 0;
        for (int lv = 1; lv <= NLEV; lv++) begin
            if (int'(slot) >= base && int'(slot) < base + (GROUP >> lv)) begin
                t.level = LVL_W'(lv);
                t.index = IDX_W'(int'(slot) - base);
            end
            base = base + (GROUP >> lv);
        end
        if (int'(slot) == GROUP - 1) begin
            t.is_low = 1'b1;
            t.level  = LVL_W'(NLEV);
            t.index  = '0;
        end
        return t;
    endfunction

endpackage

// File: rtl/htf_collect.sv
module htf_collect
    import htf_pkg::*;
#(
    parameter int COEF_W = 11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [COEF_W-1:0]            wr_data,
    output logic [GROUP-1:0][COEF_W-1:0] grp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grp <= '0;
        end else if (wr_en) begin
            grp[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/htf_lift.sv
module htf_lift
    import htf_pkg::*;
#(
    parameter int COEF_W = 11
) (
    input  logic [GROUP-1:0][COEF_W-1:0] grp,
    output logic [GROUP-1:0][COEF_W-1:0] coef,
    output logic [GROUP-1:0][COEF_W-1:0] rec
);
    // Low-pass chain: level s occupies entries starting at 2*GROUP - (2*GROUP >> s).
    logic signed [COEF_W-1:0] fwd_lo [CHAIN];
    logic signed [COEF_W-1:0] inv_lo [CHAIN];

    for (genvar f = 0; f < GROUP; f++) begin : g_taps
        assign fwd_lo[f] = $signed(grp[f]);
        assign rec[f]    = inv_lo[f];
    end

    assign inv_lo[CHAIN-1]  = $signed(grp[GROUP-1]);
    assign coef[GROUP-1]    = fwd_lo[CHAIN-1];

    for (genvar s = 1; s <= NLEV; s++) begin : g_level
        localparam int IOFF = 2 * GROUP - ((2 * GROUP) >> (s - 1));
        localparam int OOFF = 2 * GROUP - ((2 * GROUP) >> s);
        localparam int COFF = GROUP - ((2 * GROUP) >> s);
        for (genvar k = 0; k < (GROUP >> s); k++) begin : g_pair
            logic signed [COEF_W-1:0] a_even, a_hp;
            logic signed [COEF_W-1:0] s_hp, s_even;
            // forward: predict, then update
            assign a_even = fwd_lo[IOFF + 2*k];
            assign a_hp   = fwd_lo[IOFF + 2*k + 1] - a_even;
            assign fwd_lo[OOFF + k] = a_even + (a_hp >>> 1);
            assign coef[COFF + k]   = a_hp;
            // inverse: undo update, then undo predict
            assign s_hp   = $signed(grp[COFF + k]);
            assign s_even = inv_lo[OOFF + k] - (s_hp >>> 1);
            assign inv_lo[IOFF + 2*k]     = s_even;
            assign inv_lo[IOFF + 2*k + 1] = s_even + s_hp;
        end
    end
endmodule

// File: rtl/htf_emit.sv
module htf_emit
    import htf_pkg::*;
#(
    parameter int COEF_W = 11
) (
    input  lift_mode_e                   mode,
    input  logic [IDX_W-1:0]             slot,
    input  logic [GROUP-1:0][COEF_W-1:0] coef,
    input  logic [GROUP-1:0][COEF_W-1:0] rec,
    output logic [COEF_W-1:0]            data,
    output coef_tag_t                    tag
);
    always_comb begin
        if (mode == MODE_SYNTHESIS) begin
            data       = rec[slot];
            tag.is_low = 1'b1;
            tag.level  = '0;
            tag.index  = slot;
        end else begin
            data = coef[slot];
            tag  = analysis_tag(slot);
        end
    end
endmodule

// File: rtl/haar_temporal_filter.sv
module haar_temporal_filter
    import htf_pkg::*;
#(
    parameter  int SAMPLE_W = 8,
    localparam int COEF_W   = SAMPLE_W + htf_pkg::NLEV
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mode_i,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [COEF_W-1:0]          in_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [COEF_W-1:0]          out_data,
    output logic                       out_is_low,
    output logic [htf_pkg::LVL_W-1:0]  out_level,
    output logic [htf_pkg::IDX_W-1:0]  out_index
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUP - 1);

    phase_e           phase;
    logic [IDX_W-1:0] pos;
    lift_mode_e       grp_mode;

    logic accept, handoff;
    logic [GROUP-1:0][COEF_W-1:0] grp, coef, rec;
    coef_tag_t tag;

    assign in_ready  = (phase == PH_COLLECT);
    assign out_valid = (phase == PH_EMIT);
    assign accept    = in_valid && in_ready;
    assign handoff   = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_COLLECT;
            pos      <= '0;
            grp_mode <= MODE_ANALYSIS;
        end else if (phase == PH_COLLECT) begin
            if (accept) begin
                if (pos == '0) grp_mode <= lift_mode_e'(mode_i);
                if (pos == LAST) begin
                    phase <= PH_EMIT;
                    pos   <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end else if (handoff) begin
            if (pos == LAST) begin
                phase <= PH_COLLECT;
                pos   <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    htf_collect #(.COEF_W(COEF_W)) u_collect (
        .clk(clk), .rst(rst), .wr_en(accept), .wr_idx(pos),
        .wr_data(in_data), .grp(grp)
    );

    htf_lift #(.COEF_W(COEF_W)) u_lift (
        .grp(grp), .coef(coef), .rec(rec)
    );

    htf_emit #(.COEF_W(COEF_W)) u_emit (
        .mode(grp_mode), .slot(pos), .coef(coef), .rec(rec),
        .data(out_data), .tag(tag)
    );

    assign out_is_low = tag.is_low;
    assign out_level  = tag.level;
    assign out_index  = tag.index;
endmodule

// File: rtl/htf_checker.sv
module htf_checker
    import htf_pkg::*;
#(
    parameter int COEF_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [COEF_W-1:0] out_data,
    input logic              out_is_low,
    input logic [LVL_W-1:0]  out_level,
    input logic [IDX_W-1:0]  out_index
);
    // R1: collecting and emitting never overlap
    a_r1_phase_excl: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R8: a stalled result holds still
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_is_low) && $stable(out_level) && $stable(out_index)));

    // R5 / R6: emission opens on index 0
    a_r5_first_index: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_index == '0));

    // R5: only low-pass or rebuilt frames may carry level 0
    a_r5_tag_legal: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_low) |-> (out_level != '0));

    // R9: input reopens right after the final handoff
    a_r9_reopen: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_is_low &&
         (out_level == LVL_W'(NLEV) || out_index == IDX_W'(GROUP - 1)))
        |=> (in_ready && !out_valid));
endmodule

bind haar_temporal_filter htf_checker #(.COEF_W(COEF_W)) u_htf_checker (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_is_low(out_is_low),
    .out_level(out_level), .out_index(out_index)
);

// File: tb/tb_haar_temporal_filter.sv
module tb_haar_temporal_filter;
    localparam int SW = 8;
    localparam int CW = SW + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_i = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [CW-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [CW-1:0] out_data;
    logic out_is_low;
    logic [1:0] out_level;
    logic [2:0] out_index;

    always #5 clk = ~clk;

    haar_temporal_filter #(.SAMPLE_W(SW)) dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_is_low(out_is_low),
        .out_level(out_level), .out_index(out_index)
    );

    typedef struct {
        int    val;
        bit    low;
        int    lvl;
        int    idx;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference from R3/R4: forward lifting, three levels.
    task automatic ref_analysis(input int x[8], output int c[8]);
        int lo[8];
        int n, base;
        for (int i = 0; i < 8; i++) lo[i] = x[i];
        n = 8; base = 0;
        for (int lv = 1; lv <= 3; lv++) begin
            for (int k = 0; k < n / 2; k++) begin
                int h;
                h = lo[2*k+1] - lo[2*k];
                c[base + k] = h;
                lo[k] = lo[2*k] + (h >>> 1);
            end
            base = base + n / 2;
            n = n / 2;
        end
        c[7] = lo[0];
    endtask

    task automatic push_analysis_exp(input int x[8], input string req);
        int c[8];
        ref_analysis(x, c);
        for (int j = 0; j < 8; j++) begin
            exp_t e;
            e.val = c[j];
            e.req = req;
            if (j < 4)      begin e.low = 0; e.lvl = 1; e.idx = j;     end
            else if (j < 6) begin e.low = 0; e.lvl = 2; e.idx = j - 4; end
            else if (j == 6) begin e.low = 0; e.lvl = 3; e.idx = 0;   end
            else            begin e.low = 1; e.lvl = 3; e.idx = 0;     end
            exp_q.push_back(e);
        end
    endtask

    task automatic push_synth_exp(input int x[8], input string req);
        for (int j = 0; j < 8; j++) begin
            exp_t e;
            e.val = x[j]; e.low = 1; e.lvl = 0; e.idx = j; e.req = req;
            exp_q.push_back(e);
        end
    endtask

    // Driver: holds in_valid until the block accepts each value.
    task automatic drive_group(input bit m, input int v[8], input bit flip);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = CW'(v[j]);
            mode_i   = (flip && j > 0) ? ~m : m;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
        end
    endtask

    task automatic analysis_group(input int x[8], input bit flip, input string req);
        push_analysis_exp(x, req);
        drive_group(1'b0, x, flip);
    endtask

    task automatic synthesis_group(input int x[8], input bit flip, input string req);
        int c[8];
        ref_analysis(x, c);
        push_synth_exp(x, req);
        drive_group(1'b1, c, flip);
    endtask

    // Output backpressure
    always @(posedge clk) begin
        #1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            // R1 and R9: input closed during emission even with in_valid held
            if (in_valid)
                check(in_ready == 1'b0, "R9", "in_ready while emitting", int'(in_ready), 0);
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected result", int'($signed(out_data)), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'($signed(out_data)) == e.val, e.req, "data",
                          int'($signed(out_data)), e.val);
                    check(out_is_low == e.low && int'(out_level) == e.lvl &&
                          int'(out_index) == e.idx, "R5", "tag",
                          {out_is_low, out_level, out_index},
                          {e.low, 2'(e.lvl), 3'(e.idx)});
                end
            end
        end
    end

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        int g_ramp[8]   = '{0, 1, 2, 3, 4, 5, 6, 7};
        int g_ext[8]    = '{-128, 127, -128, 127, 127, -128, 127, -128};
        int g_odd[8]    = '{5, -3, 0, -1, 9, 2, -7, -8};
        int g_const[8]  = '{-50, -50, -50, -50, -50, -50, -50, -50};
        int g_mix[8]    = '{127, -128, -1, 0, 33, -77, 100, -100};

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R2: first result the cycle after the eighth accept
        push_analysis_exp(g_ramp, "R3");
        drive_group(1'b0, g_ramp, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R2", "out_valid after eighth accept", int'(out_valid), 1);
        while (exp_q.size() != 0) @(negedge clk);

        // R3 / R4: odd values exercise floor rounding of negative halves
        analysis_group(g_odd, 1'b0, "R4");
        // R10: alternating extremes, back to back so R9 is provoked
        analysis_group(g_ext, 1'b0, "R10");
        analysis_group(g_const, 1'b0, "R3");

        // R8: random stalls
        stall_en = 1'b1;
        analysis_group(g_mix, 1'b0, "R8");
        // R6: exact rebuild, under stalls
        synthesis_group(g_odd, 1'b0, "R6");
        synthesis_group(g_ext, 1'b0, "R6");
        // R7: mode flipped after the first value of a group
        analysis_group(g_ramp, 1'b1, "R7");
        synthesis_group(g_mix, 1'b1, "R7");
        stall_en = 1'b0;
        // R9: group following a held request still lines up
        analysis_group(g_mix, 1'b0, "R9");
        @(negedge clk);
        in_valid = 1'b0;

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after last group",
              {in_ready, out_valid}, 2);
        finish_up();
    end
endmodule